// File: doc/BRIEF.md
# Wake Interrupt Polarity Normalizer

This block is a bank of per-pin interrupt front ends. It sits between external wake sources and a parent interrupt controller that accepts only two forms: an active-high level or a rising edge. Each pin has a 3-bit trigger code and an enable bit. Both are held in a small register file reached over a word-addressed write/read bus. Every raw input passes through a two-flop synchronizer. Each pin then drives one output toward the parent. A level pin presents an active-high level. An edge pin (rising, falling or both edges) presents a pulse exactly one clock wide.

Rewriting a pin's trigger code can flip the normalized signal while the input itself has not moved. That flip would look like a phantom edge. To prevent it, each pin has a small guard state machine with two states, `GUARD_OPEN` and `GUARD_HOLD`.
- A bus write that changes the pin's code moves the guard from `GUARD_OPEN` to `GUARD_HOLD`.
- Edge output is blocked during the write cycle itself and for the whole `GUARD_HOLD` cycle.
- The guard returns to `GUARD_OPEN` on the next cycle that carries no further changing write. A further changing write keeps it in `GUARD_HOLD`.

The bus address counts 32-bit words. Byte offset B corresponds to word B/4.

Top module: `wake_norm_top`

## Requirements
- R1: Trigger codes are 000 level active-low, 010 falling edge, 100 level active-high, 110 rising edge and 111 both edges. The unused codes 001, 011 and 101 keep the pin output low.
- R2: An enabled pin with code 100 drives its output high while its input is high, and low while the input is low.
- R3: An enabled pin with code 000 drives its output high while its input is low, and low while the input is high.
- R4: An enabled pin with code 110 emits a pulse exactly one clock wide on each rising input transition. It emits nothing on falling transitions.
- R5: An enabled pin with code 010 emits a pulse exactly one clock wide on each falling input transition. It emits nothing on rising transitions.
- R6: An enabled pin with code 111 emits a pulse exactly one clock wide on every input transition, in either direction.
- R7: A pin whose enable bit is clear keeps its output low. Clearing the enable of an active pin forces its output low on the cycle after the write is taken.
- R8: Enable bits are packed 32 per word, starting at word 4 (byte 0x10). Pin p uses word 4 + p/32, bit p%32. Bits for pins that do not exist read back as 0.
- R9: The trigger code of pin p sits in bits [2:0] of word 68 + p (byte 0x110 + 4p). Upper write bits are dropped, and upper read bits are 0.
- R10: After reset, every enable bit and every trigger code is 0, and every output is low.
- R11: A read of any word that holds no enable bank and no trigger code returns 0.
- R12: A write that changes a pin's trigger code moves its guard to `GUARD_HOLD`. No edge pulse reaches the output for that pin from the write cycle or from the following cycle. A polarity flip on a steady input therefore produces no output pulse.
- R13: An input change driven before clock edge k shows on the output after clock edge k+2: two synchronizer flops plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W | Word address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| wake_in | input | NUM_PINS | Raw asynchronous wake sources |
| parent_irq | output | NUM_PINS | Normalized per-pin requests toward the parent controller |

## Verification
The bench builds the block with NUM_PINS = 40 and keeps the default ADDR_W of 10. With 40 pins the enable bank spans two words, and the second word is only partly populated. This makes the word/bit split of R8 observable: upper bits of word 5 read back as 0. A rising-edge pin on word 5 shows that the split reaches the datapath. It also places the first unimplemented trigger word, word 108, within easy reach of R11. Each trigger mode is probed over a five-cycle window after every input change. This pins down both the R13 latency and the one-cycle pulse width. The phantom case rewrites a rising pin to falling while its input sits low.

// File: rtl/wake_norm_pkg.sv
package wake_norm_pkg;

    // Per-pin trigger codes; the bit values are fixed by software.
    typedef enum logic [2:0] {
        TRIG_LVL_LOW  = 3'b000,
        TRIG_FALL     = 3'b010,
        TRIG_LVL_HIGH = 3'b100,
        TRIG_RISE     = 3'b110,
        TRIG_BOTH     = 3'b111
    } trig_e;

    // Phantom-edge guard states.
    typedef enum logic {
        GUARD_OPEN = 1'b0,
        GUARD_HOLD = 1'b1
    } guard_e;

    localparam int BUS_DW      = 32;
    localparam int EN_WORD_BASE  = 4;   // byte 0x10
    localparam int CFG_WORD_BASE = 68;  // byte 0x110

endpackage

// File: rtl/wake_norm_regfile.sv
module wake_norm_regfile
    import wake_norm_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BUS_DW-1:0]           wdata,
    output logic [BUS_DW-1:0]           rdata,
    output logic [NUM_PINS-1:0]         pin_en,
    output logic [NUM_PINS-1:0][2:0]    pin_cfg,
    output logic [NUM_PINS-1:0]         cfg_chg
);

    localparam int EN_WORDS = (NUM_PINS + BUS_DW - 1) / BUS_DW;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(EN_WORD_BASE + p / BUS_DW);
        localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_WORD_BASE + p);
        localparam int                EN_BIT   = p % BUS_DW;

        logic       en_r;
        logic [2:0] cfg_r;
        logic       hit_cfg;

        assign hit_cfg    = wr_en && (addr == CFG_ADDR);
        assign cfg_chg[p] = hit_cfg && (wdata[2:0] != cfg_r);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_r  <= 1'b0;
                cfg_r <= 3'b000;
            end else begin
                if (wr_en && (addr == EN_ADDR)) en_r <= wdata[EN_BIT];
                if (hit_cfg)                    cfg_r <= wdata[2:0];
            end
        end

        assign pin_en[p]  = en_r;
        assign pin_cfg[p] = cfg_r;
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr == ADDR_W'(EN_WORD_BASE + p / BUS_DW)) rdata[p % BUS_DW] = pin_en[p];
            if (addr == ADDR_W'(CFG_WORD_BASE + p))         rdata[2:0]        = pin_cfg[p];
        end
    end

    // Words below the enable bank and between the two banks hold nothing.
    assert_hole_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr < ADDR_W'(EN_WORD_BASE)) ||
         ((addr >= ADDR_W'(EN_WORD_BASE + EN_WORDS)) && (addr < ADDR_W'(CFG_WORD_BASE))))
        |-> (rdata == '0));

    // A trigger word only ever carries a 3-bit code.
    assert_cfg_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ADDR_W'(CFG_WORD_BASE)) |-> (rdata[BUS_DW-1:3] == '0));

endmodule

// File: rtl/wake_norm_pin.sv
module wake_norm_pin
    import wake_norm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_raw,
    input  logic       pin_en,
    input  logic [2:0] pin_cfg,
    input  logic       cfg_chg,
    output logic       irq_o
);

    logic   sync1, sync2, raw_q, norm_q;
    logic   invert, is_level, is_single, is_dual, is_edge;
    logic   norm, edge_raw, edge_ok;
    guard_e guard_q, guard_d;

    // Decode of the trigger code.
    always_comb begin
        invert    = (pin_cfg == TRIG_LVL_LOW) || (pin_cfg == TRIG_FALL);
        is_level  = (pin_cfg == TRIG_LVL_LOW) || (pin_cfg == TRIG_LVL_HIGH);
        is_single = (pin_cfg == TRIG_RISE)    || (pin_cfg == TRIG_FALL);
        is_dual   = (pin_cfg == TRIG_BOTH);
        is_edge   = is_single || is_dual;
    end

    // Normalization and edge detection on the synchronized input.
    always_comb begin
        norm     = sync2 ^ invert;
        edge_raw = (is_single && norm && !norm_q) || (is_dual && (sync2 ^ raw_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1  <= 1'b0;
            sync2  <= 1'b0;
            raw_q  <= 1'b0;
            norm_q <= 1'b0;
        end else begin
            sync1  <= wake_raw;
            sync2  <= sync1;
            raw_q  <= sync2;
            norm_q <= norm;
        end
    end

    // Guard state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) guard_q <= GUARD_OPEN;
        else        guard_q <= guard_d;
    end

    // Guard next-state logic.
    always_comb begin
        guard_d = guard_q;
        unique case (guard_q)
            GUARD_OPEN: if (cfg_chg)  guard_d = GUARD_HOLD;
            GUARD_HOLD: if (!cfg_chg) guard_d = GUARD_OPEN;
            default:                  guard_d = GUARD_OPEN;
        endcase
    end

    // Guard output: edges pass only when open and no changing write is present.
    always_comb begin
        edge_ok = (guard_q == GUARD_OPEN) && !cfg_chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pin_en && ((is_level && norm) || (edge_raw && edge_ok));
    end

    assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |=> !irq_o);

    assert_unused_code_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_level || is_edge) |=> !irq_o);

    assert_change_enters_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (guard_q == GUARD_HOLD));

    assert_hold_blocks_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((guard_q == GUARD_HOLD) && is_edge) |=> !irq_o);

    assert_single_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && is_single) |=> !irq_o);

endmodule

// File: rtl/wake_norm_top.sv
module wake_norm_top
    import wake_norm_pkg::*;
#(
    parameter int NUM_PINS = 168,
    parameter int ADDR_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]  wake_in,
    output logic [NUM_PINS-1:0]  parent_irq
);

    logic [NUM_PINS-1:0]      pin_en;
    logic [NUM_PINS-1:0][2:0] pin_cfg;
    logic [NUM_PINS-1:0]      cfg_chg;

    wake_norm_regfile #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .pin_en  (pin_en),
        .pin_cfg (pin_cfg),
        .cfg_chg (cfg_chg)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_front
        wake_norm_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .wake_raw (wake_in[p]),
            .pin_en   (pin_en[p]),
            .pin_cfg  (pin_cfg[p]),
            .cfg_chg  (cfg_chg[p]),
            .irq_o    (parent_irq[p])
        );
    end

endmodule

// File: tb/wake_norm_top_tb.sv
module wake_norm_top_tb_top;

    localparam int NP = 40;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] wake_in = '0;
    logic [NP-1:0] parent_irq;
    logic [63:0]   en_sh = '0;
    int            n_run = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    wake_norm_top #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_in(wake_in), .parent_irq(parent_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input int word, input logic [31:0] data);
        bus_wr = 1'b1; bus_addr = AW'(word); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int word, output logic [31:0] data);
        bus_addr = AW'(word);
        #1 data = bus_rdata;
    endtask

    task automatic set_cfg(input int p, input logic [2:0] code);
        wr(68 + p, {29'd0, code});
    endtask

    task automatic set_en(input int p, input logic v);
        en_sh[p] = v;
        wr(4 + p / 32, en_sh[(p / 32) * 32 +: 32]);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Sample one pin for five cycles after a stimulus; bit i = cycle i+1.
    task automatic probe(input int p, output logic [4:0] got);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            got[i] = parent_irq[p];
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R10 outputs low", 32'(parent_irq), 32'h0);
        rd(4, d);  chk("R10 enable word0", d, 32'h0);
        rd(5, d);  chk("R10 enable word1", d, 32'h0);
        rd(68, d); chk("R10 cfg pin0", d, 32'h0);
        rd(68 + 39, d); chk("R10 cfg pin39", d, 32'h0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(4, 32'hA5A5_5A5A); rd(4, d); chk("R8 word0 readback", d, 32'hA5A5_5A5A);
        wr(5, 32'hFFFF_FFFF); rd(5, d); chk("R8 word1 missing pins", d, 32'h0000_00FF);
        wr(4, 32'h0); wr(5, 32'h0);
        wr(68 + 5, 32'hFFFF_FFF6); rd(68 + 5, d); chk("R9 cfg low bits", d, 32'h6);
        wr(68 + 5, 32'h0);
        rd(0, d);       chk("R11 word0", d, 32'h0);
        rd(3, d);       chk("R11 word3", d, 32'h0);
        rd(6, d);       chk("R11 after enable bank", d, 32'h0);
        rd(68 + 40, d); chk("R11 past last cfg", d, 32'h0);
        wait_n(2);
    endtask

    task automatic t_level_high;
        logic [4:0] g;
        set_cfg(3, 3'b100); set_en(3, 1'b1); wait_n(3);
        wake_in[3] = 1'b1; probe(3, g); chk("R2 R13 level high rise", 32'(g), 32'(5'b11100));
        wake_in[3] = 1'b0; probe(3, g); chk("R2 level high fall", 32'(g), 32'(5'b00011));
    endtask

    task automatic t_level_low;
        logic [4:0] g;
        set_cfg(7, 3'b000); set_en(7, 1'b1); wait_n(4);
        chk("R3 idle low input asserts", 32'(parent_irq[7]), 32'h1);
        wake_in[7] = 1'b1; probe(7, g); chk("R3 high input deasserts", 32'(g), 32'(5'b00011));
        wake_in[7] = 1'b0; probe(7, g); chk("R3 low input reasserts", 32'(g), 32'(5'b11100));
    endtask

    task automatic t_rise;
        logic [4:0] g;
        set_cfg(33, 3'b110); set_en(33, 1'b1); wait_n(4);
        wake_in[33] = 1'b1; probe(33, g); chk("R4 R8 rise pulse word1", 32'(g), 32'(5'b00100));
        wake_in[33] = 1'b0; probe(33, g); chk("R4 no pulse on fall", 32'(g), 32'h0);
    endtask

    task automatic t_fall;
        logic [4:0] g;
        wake_in[10] = 1'b1; wait_n(4);
        set_cfg(10, 3'b010); set_en(10, 1'b1); wait_n(4);
        wake_in[10] = 1'b0; probe(10, g); chk("R5 fall gives one pulse", 32'(g), 32'(5'b00100));
        wake_in[10] = 1'b1; probe(10, g); chk("R5 no pulse on rise", 32'(g), 32'h0);
    endtask

    task automatic t_dual;
        logic [4:0] g;
        set_cfg(20, 3'b111); set_en(20, 1'b1); wait_n(4);
        wake_in[20] = 1'b1; probe(20, g); chk("R6 dual on rise", 32'(g), 32'(5'b00100));
        wake_in[20] = 1'b0; probe(20, g); chk("R6 dual on fall", 32'(g), 32'(5'b00100));
    endtask

    task automatic t_disabled;
        logic [4:0] g;
        set_cfg(21, 3'b100); wait_n(2);
        wake_in[21] = 1'b1; probe(21, g); chk("R7 disabled level pin", 32'(g), 32'h0);
        wake_in[3] = 1'b1; wait_n(4);
        chk("R7 pin3 active before disable", 32'(parent_irq[3]), 32'h1);
        set_en(3, 1'b0); @(negedge clk);
        chk("R7 disable forces low", 32'(parent_irq[3]), 32'h0);
        wake_in[3] = 1'b0;
    endtask

    task automatic t_unused;
        logic [4:0] g;
        set_cfg(22, 3'b101); set_en(22, 1'b1); wait_n(2);
        wake_in[22] = 1'b1; probe(22, g); chk("R1 code 101 silent", 32'(g), 32'h0);
        set_cfg(22, 3'b011); wait_n(2);
        wake_in[22] = 1'b0; probe(22, g); chk("R1 code 011 silent", 32'(g), 32'h0);
        set_cfg(22, 3'b001); wait_n(2);
        chk("R1 code 001 silent on low input", 32'(parent_irq[22]), 32'h0);
    endtask

    task automatic t_phantom;
        logic [4:0] g;
        int highs;
        set_cfg(25, 3'b110); set_en(25, 1'b1); wait_n(4);
        set_cfg(25, 3'b010);
        highs = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (parent_irq[25]) highs++;
        end
        chk("R12 no phantom after polarity flip", 32'(highs), 32'h0);
        wake_in[25] = 1'b1; probe(25, g); chk("R12 rise ignored after flip", 32'(g), 32'h0);
        wake_in[25] = 1'b0; probe(25, g); chk("R12 falling works after flip", 32'(g), 32'(5'b00100));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall();
        t_dual();
        t_disabled();
        t_unused();
        t_phantom();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule